// File: doc/BRIEF.md
# Byte Stream to 32-bit Word Packer

This block sits in front of a checksum engine that consumes whole 32-bit words only. Upstream logic hands it bytes one per beat, grouped into submissions of any length. Each submission ends with a beat that carries an end mark. The packer gathers bytes little-endian into words and forwards only complete words. When a submission's length is not a multiple of four, the leftover one to three bytes stay in a carry store and form the low lanes of the next submission's first word.

A submission may also be marked final. The final mark may ride on the end beat of a data submission, or on an end beat that carries no byte, which acts as a finish request. After a final mark, any carried bytes are sent as one last word with zeros in the empty upper lanes. Once that word has been taken downstream, a single-cycle done pulse is raised and the carry is empty again. A word counter reports how many words have been emitted for the current submission. It restarts on the first beat of each new submission.

Top module: `byte_word_packer`

## Requirements
- R1: Bytes are packed little-endian: the first byte received occupies bits 7:0 of a word, the fourth occupies bits 31:24, and a word is emitted only once four bytes are gathered.
- R2: On an end beat that is not final, the 1 to 3 leftover bytes are kept and become the lowest lanes of the first word of the next submission, ahead of its own bytes.
- R3: If the carried bytes plus a non-final submission total fewer than four, no word is emitted and the bytes accumulate.
- R4: After a final mark with a non-empty carry, the carried bytes are emitted as one word whose unused upper lanes are zero, and that word counts toward the submission.
- R5: A finish request (in_keep=0, in_last=1, in_final=1) with an empty carry emits no word and still produces a done pulse.
- R6: A zero-length update (in_keep=0, in_last=1, in_final=0) emits no word, leaves the carry unchanged, and the submission's count reads 0.
- R7: out_count equals the number of words emitted for the current submission, which is floor((carried + new bytes)/4), plus one when final with a remainder. It restarts at the first accepted beat of the next submission.
- R8: done is a single-cycle pulse raised only after the last word of a final submission has been accepted, with the output empty and the carry cleared.
- R9: While out_valid is high and out_ready is low, out_data holds steady, and no byte is lost or overwritten.
- R10: After reset, out_valid, done and out_count are 0, the carry is empty, and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Packer can take the beat |
| in_data | input | 8 | Byte carried by the beat |
| in_keep | input | 1 | 1 when the beat carries a byte, 0 for a marker-only beat |
| in_last | input | 1 | Beat ends the submission |
| in_final | input | 1 | With in_last, flush the carry and signal done |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed word, first byte in bits 7:0 |
| out_count | output | 16 | Words emitted for the current submission |
| done | output | 1 | One-cycle completion pulse after a final submission |

## Verification
A wrong byte index or fill count in the carry store shows up in the first word that mixes old and new bytes. Such a word is emitted at most four accepted beats later, with lanes shifted or duplicated. A carry that was not cleared after a flush shows up as stale bytes in the next submission's first word. A finish request that sees a non-empty carry shows up as a spurious padded word. A lost pending-final state shows up within a few cycles as a missing done pulse, and a stuck one shows up as in_ready that never returns. A counter that restarts on the wrong beat shows up in out_count as soon as the submission settles.

// File: rtl/packer_pkg.sv
package packer_pkg;
  localparam int unsigned BYTE_BITS = 8;
  typedef logic [BYTE_BITS-1:0] byte_t;
endpackage

// File: rtl/pk_carry.sv
module pk_carry #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [BYTE_W-1:0]        byte_in,
  input  logic                     clear,
  output logic [$clog2(LANES)-1:0] fill,
  output logic                     full,
  output logic [LANES*BYTE_W-1:0]  word
);
  localparam int unsigned FW = $clog2(LANES);
  localparam logic [FW-1:0] LAST = FW'(LANES-1);

  logic [BYTE_W-1:0] hold [LANES-1];

  assign full = push && (fill == LAST);

  // Lane assembly: stored bytes below fill, incoming byte at fill, zeros above.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < LANES-1) begin : g_low
      assign word[i*BYTE_W +: BYTE_W] =
        (FW'(i) < fill)            ? hold[i] :
        (FW'(i) == fill && push)   ? byte_in : '0;
    end else begin : g_top
      assign word[i*BYTE_W +: BYTE_W] = full ? byte_in : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!full && push) hold[fill] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (rst)            fill <= '0;
    else if (clear)     fill <= '0;
    else if (full)      fill <= '0;
    else if (push)      fill <= fill + 1'b1;
  end

  assert_fill_step_R1: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !clear) |=> (fill == $past(fill) + 1'b1));
  assert_carry_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!push && !clear) |=> $stable(fill));
endmodule

// File: rtl/pk_slot.sv
module pk_slot #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= word_in;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid);
  assert_hold_word_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pk_ctl.sv
module pk_ctl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_fire,
  input  logic             beat_last,
  input  logic             beat_final,
  input  logic             word_load,
  input  logic             slot_busy,
  input  logic             carry_empty,
  output logic             fin_pend,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  logic sub_start;
  logic done_evt;

  assign done_evt = fin_pend && !slot_busy && carry_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_pend <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= done_evt;
      if (beat_fire && beat_last && beat_final) fin_pend <= 1'b1;
      else if (done_evt)                        fin_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_start <= 1'b1;
      count     <= '0;
    end else begin
      if (beat_fire) sub_start <= beat_last;
      if (beat_fire && sub_start) count <= word_load ? CNT_W'(1) : '0;
      else if (word_load)         count <= count + 1'b1;
    end
  end

  assert_done_clean_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (carry_empty && !slot_busy));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (word_load && !beat_fire) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W-1:0]       in_data,
  input  logic                    in_keep,
  input  logic                    in_last,
  input  logic                    in_final,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*BYTE_W-1:0] out_data,
  output logic [CNT_W-1:0]        out_count,
  output logic                    done
);
  localparam int unsigned FW     = $clog2(LANES);
  localparam int unsigned WORD_W = LANES*BYTE_W;
  localparam logic [FW-1:0] LAST = FW'(LANES-1);

  logic [FW-1:0]     fill;
  logic              full;
  logic [WORD_W-1:0] word;
  logic              fin_pend;
  logic              fire, push, flush_load, load;

  assign in_ready   = !fin_pend && !((fill == LAST) && out_valid);
  assign fire       = in_valid && in_ready;
  assign push       = fire && in_keep;
  assign flush_load = fin_pend && !out_valid && (fill != '0);
  assign load       = full || flush_load;

  pk_carry #(.LANES(LANES), .BYTE_W(BYTE_W)) carry_i (
    .clk(clk), .rst(rst), .push(push), .byte_in(in_data),
    .clear(flush_load), .fill(fill), .full(full), .word(word)
  );

  pk_slot #(.WORD_W(WORD_W)) slot_i (
    .clk(clk), .rst(rst), .load(load), .word_in(word),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  pk_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk(clk), .rst(rst), .beat_fire(fire), .beat_last(in_last),
    .beat_final(in_final), .word_load(load), .slot_busy(out_valid),
    .carry_empty(fill == '0), .fin_pend(fin_pend), .done(done),
    .count(out_count)
  );

  assert_pad_only_final_R4: assert property (@(posedge clk) disable iff (rst)
    (load && !push) |-> fin_pend);
endmodule

// File: tb/byte_word_packer_tb_top.sv
module byte_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_keep, in_last, in_final;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, done;
  logic [31:0] out_data;
  logic [15:0] out_count;

  int checks = 0;
  int errs   = 0;
  logic [31:0] cap [64];
  int cap_n    = 0;
  int done_cnt = 0;
  int wide_cnt = 0;
  logic done_q = 1'b0;

  always #5 clk = ~clk;

  byte_word_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_keep(in_keep), .in_last(in_last),
    .in_final(in_final), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_count(out_count), .done(done)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready && cap_n < 64) begin
        cap[cap_n] <= out_data;
        cap_n <= cap_n + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
      if (done && done_q) wide_cnt <= wide_cnt + 1;
    end
    done_q <= done;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic k, input logic l, input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_keep = k; in_last = l; in_final = f;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_keep = 1'b0; in_last = 1'b0; in_final = 1'b0;
  endtask

  task automatic send_seq(input logic [7:0] start, input int n, input logic fin);
    for (int i = 0; i < n; i++) put(start + 8'(i), 1'b1, i == n-1, fin);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 done", {31'd0, done}, 32'd0);
    chk("R10 count", {16'd0, out_count}, 32'd0);
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_order();
    int b = cap_n;
    send_seq(8'h01, 8, 1'b0);
    settle();
    chk("R1 words", cap_n - b, 2);
    chk("R1 word0", cap[b], 32'h04030201);
    chk("R1 word1", cap[b+1], 32'h08070605);
    chk("R7 count", {16'd0, out_count}, 32'd2);
  endtask

  task automatic t_carry();
    int b = cap_n;
    int d0 = done_cnt;
    send_seq(8'h11, 6, 1'b0);
    settle();
    chk("R2 first chunk words", cap_n - b, 1);
    chk("R2 first word", cap[b], 32'h14131211);
    chk("R7 count chunk1", {16'd0, out_count}, 32'd1);
    send_seq(8'h21, 3, 1'b0);
    settle();
    chk("R2 second chunk words", cap_n - b, 2);
    chk("R2 joined word", cap[b+1], 32'h22211615);
    chk("R7 count chunk2", {16'd0, out_count}, 32'd1);
    chk("R8 no done yet", done_cnt - d0, 0);
    put(8'h00, 1'b0, 1'b1, 1'b1);
    settle();
    chk("R4 padded words", cap_n - b, 3);
    chk("R4 padded word", cap[b+2], 32'h00000023);
    chk("R7 count finish", {16'd0, out_count}, 32'd1);
    chk("R8 done once", done_cnt - d0, 1);
  endtask

  task automatic t_small();
    int b = cap_n;
    int d0 = done_cnt;
    send_seq(8'hA1, 2, 1'b0);
    settle();
    chk("R3 no word", cap_n - b, 0);
    chk("R3 count", {16'd0, out_count}, 32'd0);
    put(8'h00, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R6 no word", cap_n - b, 0);
    chk("R6 count", {16'd0, out_count}, 32'd0);
    chk("R6 no done", done_cnt - d0, 0);
    send_seq(8'hA3, 1, 1'b1);
    settle();
    chk("R4 final words", cap_n - b, 1);
    chk("R4 R6 padded carry kept", cap[b], 32'h00A3A2A1);
    chk("R7 count final", {16'd0, out_count}, 32'd1);
    chk("R8 done", done_cnt - d0, 1);
  endtask

  task automatic t_finish_empty();
    int b = cap_n;
    int d0 = done_cnt;
    put(8'h00, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R5 done soon", done_cnt - d0, 1);
    settle();
    chk("R5 no word", cap_n - b, 0);
    chk("R5 count", {16'd0, out_count}, 32'd0);
  endtask

  task automatic t_backpressure();
    int b = cap_n;
    @(negedge clk);
    out_ready = 1'b0;
    fork
      send_seq(8'h31, 8, 1'b0);
      begin
        repeat (12) @(negedge clk);
        chk("R9 held valid", {31'd0, out_valid}, 32'd1);
        chk("R9 held word", out_data, 32'h34333231);
        repeat (4) @(negedge clk);
        chk("R9 still held", out_data, 32'h34333231);
        out_ready = 1'b1;
      end
    join
    settle();
    chk("R9 words", cap_n - b, 2);
    chk("R9 first", cap[b], 32'h34333231);
    chk("R9 second", cap[b+1], 32'h38373635);
  endtask

  task automatic t_exact_final();
    int b = cap_n;
    int d0 = done_cnt;
    send_seq(8'h41, 4, 1'b1);
    settle();
    chk("R7 exact words", cap_n - b, 1);
    chk("R1 exact word", cap[b], 32'h44434241);
    chk("R7 exact count", {16'd0, out_count}, 32'd1);
    chk("R8 exact done", done_cnt - d0, 1);
    chk("R8 single cycle", wide_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_keep = 1'b0;
    in_last = 1'b0; in_final = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_carry();
    t_small();
    t_finish_empty();
    t_backpressure();
    t_exact_final();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule